// File: doc/BRIEF.md
# Timer Control and Status Register Block

This block keeps the two configuration and event words shared by three timer engines: a decrementer, a fixed-interval timer and a watchdog. Software loads the 32-bit control word with a plain write. Software acknowledges events in the 32-bit status word by writing ones, and only those bits are cleared. Each timer engine reports an event with a one-cycle pulse that sets its own status flag.

The block drives one level interrupt per timer. Each interrupt is its status flag gated by that timer's enable bit in the control word. A fixed-interval or watchdog engine must compute its next expiry whenever its flag is acknowledged or its period may have changed. For this the block sends that engine a one-cycle re-arm pulse. A parameter selects whether the two 4-bit period extension fields in the control word are stored. All ports are plain control and status pins. No data stream crosses the boundary, so there is no valid/ready handshake.

Top module: `tmr_ctl_regs`

## Requirements
- R1: While reset is asserted, and on the first clock after it, the control word, the status word, all three interrupts and both re-arm pulses are 0.
- R2: A control write stores the written value masked to the defined fields, and the stored word appears on the next clock. The defined fields are: bits 31:30 watchdog period, 29:28 watchdog reset control, 27 watchdog interrupt enable, 26 decrementer interrupt enable, 25:24 fixed-interval period, 23 fixed-interval interrupt enable, 22 auto-reload enable. With EXT_MODE=1 they also include bits 20:17 (watchdog period extension) and 16:13 (fixed-interval period extension). Every other bit reads 0.
- R3: A status clear write clears each status bit that is 1 in the written value and leaves all other bits unchanged.
- R4: Event pulses set status bits on the next clock: fit_evt sets bit 26, dec_evt sets bit 27, wdt_evt sets bit 30, wdt_enw_set sets bit 31, and wdt_rst_set[1:0] is ORed into bits 29:28.
- R5: If an event pulse and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R6: irq_dec equals status bit 27 AND control bit 26. irq_wdt equals status bit 30 AND control bit 27. irq_fit equals status bit 26 AND control bit 23. Each is registered, so it follows the stored words one cycle later.
- R7: A clear write with bit 26 set gives a one-cycle fit_rearm pulse on the next clock. A clear write with bit 30 set gives a one-cycle wdt_rearm pulse. A clear write of other bits gives no pulse.
- R8: A control write gives one-cycle pulses on both fit_rearm and wdt_rearm on the next clock.
- R9: Status bits 25:0 always read 0, and writing ones to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 32 | Control word write value |
| sts_clr_en | input | 1 | Status clear write strobe |
| sts_clr_data | input | 32 | Ones mark the status bits to clear |
| dec_evt | input | 1 | Decrementer event pulse |
| fit_evt | input | 1 | Fixed-interval event pulse |
| wdt_evt | input | 1 | Watchdog event pulse |
| wdt_enw_set | input | 1 | Watchdog sets its enable-next flag |
| wdt_rst_set | input | 2 | Watchdog reset status bits to set |
| ctl_word | output | 32 | Stored control word |
| sts_word | output | 32 | Stored status word |
| irq_dec | output | 1 | Decrementer interrupt level |
| irq_fit | output | 1 | Fixed-interval interrupt level |
| irq_wdt | output | 1 | Watchdog interrupt level |
| fit_rearm | output | 1 | Re-arm pulse to the fixed-interval engine |
| wdt_rearm | output | 1 | Re-arm pulse to the watchdog engine |

## Verification
The assertions check on every cycle that undefined control and status bits stay 0, and that the set-over-clear priority holds for the fixed-interval flag. They also check that each interrupt equals the previous cycle's flag gated by its enable, and that re-arm pulses follow control writes and acknowledges of the matching flags. The bench scenarios must show what a single-cycle property cannot. These are the exact stored values after mixed sequences of writes, events and acknowledges, the effect of the extension fields, the reset state, and that a re-arm lasts only one cycle.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;
  localparam int unsigned WORD_W = 32;
  // status flags occupy a contiguous run at the top of the word
  localparam int unsigned STS_LO = 26;
  localparam int unsigned STS_N  = 6;
  localparam int unsigned S_FIT  = 26;
  localparam int unsigned S_DEC  = 27;
  localparam int unsigned S_WDT  = 30;
  // control enable positions
  localparam int unsigned C_WDT_EN = 27;
  localparam int unsigned C_DEC_EN = 26;
  localparam int unsigned C_FIT_EN = 23;
  localparam int unsigned N_IRQ    = 3;

  localparam logic [WORD_W-1:0] CTL_BASE_MASK = 32'hFFC0_0000;
  localparam logic [WORD_W-1:0] CTL_EXT_MASK  = 32'h001F_E000;

  function automatic logic [WORD_W-1:0] ctl_mask(input bit ext);
    return ext ? (CTL_BASE_MASK | CTL_EXT_MASK) : CTL_BASE_MASK;
  endfunction
endpackage

// File: rtl/tmr_ctl_word.sv
module tmr_ctl_word
  import tmr_regs_pkg::*;
#(
  parameter bit EXT_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] word_q
);
  localparam logic [WORD_W-1:0] MASK = ctl_mask(EXT_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wr_data & MASK;
  end
endmodule

// File: rtl/tmr_sts_word.sv
module tmr_sts_word
  import tmr_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] clr_data,
  input  logic [STS_N-1:0]  set_vec,
  output logic [WORD_W-1:0] word_q
);
  logic [STS_N-1:0] flag_q;

  for (genvar i = 0; i < STS_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag_q[i] <= 1'b0;
      else if (set_vec[i])                 flag_q[i] <= 1'b1;
      else if (clr_en && clr_data[STS_LO+i]) flag_q[i] <= 1'b0;
    end
  end

  assign word_q = {flag_q, {STS_LO{1'b0}}};
endmodule

// File: rtl/tmr_irq_rearm.sv
module tmr_irq_rearm
  import tmr_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ctl_q,
  input  logic [WORD_W-1:0] sts_q,
  input  logic              ctl_wr_en,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] clr_data,
  output logic [N_IRQ-1:0]  irq_q,
  output logic              fit_rearm_q,
  output logic              wdt_rearm_q
);
  // index 0 decrementer, 1 fixed-interval, 2 watchdog
  localparam int unsigned SBIT [N_IRQ] = '{S_DEC, S_FIT, S_WDT};
  localparam int unsigned EBIT [N_IRQ] = '{C_DEC_EN, C_FIT_EN, C_WDT_EN};

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[i] <= 1'b0;
      else        irq_q[i] <= sts_q[SBIT[i]] & ctl_q[EBIT[i]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fit_rearm_q <= 1'b0;
      wdt_rearm_q <= 1'b0;
    end else begin
      fit_rearm_q <= ctl_wr_en | (clr_en & clr_data[S_FIT]);
      wdt_rearm_q <= ctl_wr_en | (clr_en & clr_data[S_WDT]);
    end
  end
endmodule

// File: rtl/tmr_ctl_regs.sv
module tmr_ctl_regs
  import tmr_regs_pkg::*;
#(
  parameter bit EXT_MODE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr_en,
  input  logic [31:0] ctl_wr_data,
  input  logic        sts_clr_en,
  input  logic [31:0] sts_clr_data,
  input  logic        dec_evt,
  input  logic        fit_evt,
  input  logic        wdt_evt,
  input  logic        wdt_enw_set,
  input  logic [1:0]  wdt_rst_set,
  output logic [31:0] ctl_word,
  output logic [31:0] sts_word,
  output logic        irq_dec,
  output logic        irq_fit,
  output logic        irq_wdt,
  output logic        fit_rearm,
  output logic        wdt_rearm
);
  logic [STS_N-1:0] set_vec;
  logic [N_IRQ-1:0] irq_vec;

  // flag order from bit 26 upward
  assign set_vec = {wdt_enw_set, wdt_evt, wdt_rst_set, dec_evt, fit_evt};

  tmr_ctl_word #(.EXT_MODE(EXT_MODE)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en),
    .wr_data(ctl_wr_data), .word_q(ctl_word)
  );

  tmr_sts_word u_sts (
    .clk(clk), .rst_n(rst_n), .clr_en(sts_clr_en),
    .clr_data(sts_clr_data), .set_vec(set_vec), .word_q(sts_word)
  );

  tmr_irq_rearm u_out (
    .clk(clk), .rst_n(rst_n), .ctl_q(ctl_word), .sts_q(sts_word),
    .ctl_wr_en(ctl_wr_en), .clr_en(sts_clr_en), .clr_data(sts_clr_data),
    .irq_q(irq_vec), .fit_rearm_q(fit_rearm), .wdt_rearm_q(wdt_rearm)
  );

  assign irq_dec = irq_vec[0];
  assign irq_fit = irq_vec[1];
  assign irq_wdt = irq_vec[2];
endmodule

// File: rtl/tmr_ctl_regs_chk.sv
module tmr_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr_en,
  input logic        sts_clr_en,
  input logic [31:0] sts_clr_data,
  input logic        fit_evt,
  input logic [31:0] ctl_word,
  input logic [31:0] sts_word,
  input logic        irq_dec,
  input logic        irq_fit,
  input logic        irq_wdt,
  input logic        fit_rearm,
  input logic        wdt_rearm
);
  assert_ctl_undef_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word & ~32'hFFDF_E000) == 32'h0);

  assert_sts_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_word[25:0] == 26'h0);

  assert_clear_fit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr_en && sts_clr_data[26] && !fit_evt) |=> !sts_word[26]);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fit_evt |=> sts_word[26]);

  assert_irq_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (irq_dec == ($past(sts_word[27]) && $past(ctl_word[26])) &&
         irq_fit == ($past(sts_word[26]) && $past(ctl_word[23])) &&
         irq_wdt == ($past(sts_word[30]) && $past(ctl_word[27]))));

  assert_fit_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr_en && sts_clr_data[26]) |=> fit_rearm);

  assert_wdt_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr_en && sts_clr_data[30]) |=> wdt_rearm);

  assert_ctl_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> (fit_rearm && wdt_rearm));
endmodule

bind tmr_ctl_regs tmr_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .sts_clr_en(sts_clr_en),
  .sts_clr_data(sts_clr_data), .fit_evt(fit_evt), .ctl_word(ctl_word),
  .sts_word(sts_word), .irq_dec(irq_dec), .irq_fit(irq_fit), .irq_wdt(irq_wdt),
  .fit_rearm(fit_rearm), .wdt_rearm(wdt_rearm)
);

// File: tb/tmr_ctl_regs_tb_top.sv
module tmr_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [31:0] ctl_wr_data = '0;
  logic        sts_clr_en = 1'b0;
  logic [31:0] sts_clr_data = '0;
  logic        dec_evt = 1'b0, fit_evt = 1'b0, wdt_evt = 1'b0, wdt_enw_set = 1'b0;
  logic [1:0]  wdt_rst_set = '0;
  logic [31:0] ctl_word, sts_word;
  logic        irq_dec, irq_fit, irq_wdt, fit_rearm, wdt_rearm;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  tmr_ctl_regs dut_i (.*);

  // evt order: {enw, rst[1], rst[0], wdt, fit, dec}; rearm order: {wdt, fit}
  typedef struct packed {
    logic        cwe;
    logic [31:0] cd;
    logic        swe;
    logic [31:0] sd;
    logic [5:0]  evt;
    logic [31:0] x_ctl;
    logic [31:0] x_sts;
    logic [1:0]  x_rearm;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t [0:NV-1] TBL = '{
    '{1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0,         6'b000000, 32'hFFDF_E000, 32'h0,         2'b11},
    '{1'b0, 32'h0,         1'b0, 32'h0,         6'b000111, 32'hFFDF_E000, 32'h4C00_0000, 2'b00},
    '{1'b0, 32'h0,         1'b0, 32'h0,         6'b000000, 32'hFFDF_E000, 32'h4C00_0000, 2'b00},
    '{1'b0, 32'h0,         1'b1, 32'h0400_0000, 6'b000000, 32'hFFDF_E000, 32'h4800_0000, 2'b01},
    '{1'b0, 32'h0,         1'b1, 32'h0800_0000, 6'b000000, 32'hFFDF_E000, 32'h4000_0000, 2'b00},
    '{1'b0, 32'h0,         1'b1, 32'h4000_0000, 6'b000100, 32'hFFDF_E000, 32'h4000_0000, 2'b10},
    '{1'b1, 32'h0400_0000, 1'b0, 32'h0,         6'b000000, 32'h0400_0000, 32'h4000_0000, 2'b11},
    '{1'b0, 32'h0,         1'b0, 32'h0,         6'b000000, 32'h0400_0000, 32'h4000_0000, 2'b00},
    '{1'b0, 32'h0,         1'b0, 32'h0,         6'b110000, 32'h0400_0000, 32'hE000_0000, 2'b00},
    '{1'b0, 32'h0,         1'b1, 32'hFFFF_FFFF, 6'b000000, 32'h0400_0000, 32'h0,         2'b11},
    '{1'b1, 32'h0012_3456, 1'b0, 32'h0,         6'b000000, 32'h0012_2000, 32'h0,         2'b11},
    '{1'b0, 32'h0,         1'b1, 32'h03FF_FFFF, 6'b000001, 32'h0012_2000, 32'h0800_0000, 2'b00},
    '{1'b0, 32'h0,         1'b0, 32'h0,         6'b000000, 32'h0012_2000, 32'h0800_0000, 2'b00}
  };

  function automatic logic [2:0] irq_of(input logic [31:0] c, input logic [31:0] s);
    return {s[30] & c[27], s[26] & c[23], s[27] & c[26]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ctl_wr_en = v.cwe; ctl_wr_data = v.cd;
    sts_clr_en = v.swe; sts_clr_data = v.sd;
    {wdt_enw_set, wdt_rst_set, wdt_evt, fit_evt, dec_evt} = v.evt;
  endtask

  task automatic step(input vec_t v);
    drive(v);
    @(posedge clk); #1;
    drive('0);
  endtask

  function automatic vec_t mk(input logic cwe, input logic [31:0] cd,
                              input logic swe, input logic [31:0] sd,
                              input logic [5:0] evt);
    vec_t v = '0;
    v.cwe = cwe; v.cd = cd; v.swe = swe; v.sd = sd; v.evt = evt;
    return v;
  endfunction

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_tests++; n_fail++;
          $display("FAIL watchdog: actual hung expected finish");
          $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
          $finish;
        end
      end
    join_none

    // R1 reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R1 ctl", ctl_word, 32'h0);
    chk("R1 sts", sts_word, 32'h0);
    chk("R1 irq/rearm", {27'h0, irq_wdt, irq_fit, irq_dec, wdt_rearm, fit_rearm}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 post-release", {irq_wdt, irq_fit, irq_dec, wdt_rearm, fit_rearm}, 32'h0);

    // table walk: R2 ctl, R3/R4/R9 sts, R6 irq, R7/R8 rearm
    begin
      logic [31:0] pc = '0, ps = '0;
      for (int i = 0; i < NV; i++) begin
        step(TBL[i]);
        chk($sformatf("R2 row %0d ctl", i), ctl_word, TBL[i].x_ctl);
        chk($sformatf("R3 R4 row %0d sts", i), sts_word, TBL[i].x_sts);
        chk($sformatf("R6 row %0d irq", i), {29'h0, irq_wdt, irq_fit, irq_dec},
            {29'h0, irq_of(pc, ps)});
        chk($sformatf("R7 row %0d rearm", i), {30'h0, wdt_rearm, fit_rearm},
            {30'h0, TBL[i].x_rearm});
        pc = TBL[i].x_ctl; ps = TBL[i].x_sts;
      end
    end

    // R5 set wins, then plain clear removes flag and re-arms
    step(mk(1'b1, 32'h0080_0000, 1'b0, 32'h0, 6'b000010));
    chk("R5 fit set", sts_word, 32'h0C00_0000);
    step(mk(1'b0, 32'h0, 1'b1, 32'h0400_0000, 6'b000010));
    chk("R5 set over clear", sts_word, 32'h0C00_0000);
    chk("R6 irq_fit high", {31'h0, irq_fit}, 32'h1);
    step(mk(1'b0, 32'h0, 1'b1, 32'h0400_0000, 6'b000000));
    chk("R3 fit cleared", sts_word, 32'h0800_0000);
    chk("R7 fit rearm", {30'h0, wdt_rearm, fit_rearm}, 32'h1);
    chk("R6 irq lags clear", {31'h0, irq_fit}, 32'h1);
    step(mk(1'b0, 32'h0, 1'b0, 32'h0, 6'b000000));
    chk("R6 irq_fit low", {31'h0, irq_fit}, 32'h0);
    chk("R7 pulse ends", {30'h0, wdt_rearm, fit_rearm}, 32'h0);

    // R8 control write re-arms both, R9 undefined status bits ignored
    step(mk(1'b1, 32'h0, 1'b1, 32'h03FF_FFFF, 6'b000000));
    chk("R8 both rearm", {30'h0, wdt_rearm, fit_rearm}, 32'h3);
    chk("R9 sts kept", sts_word, 32'h0800_0000);

    // R1 mid-run reset
    step(mk(1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, 6'b111111));
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async ctl", ctl_word, 32'h0);
    chk("R1 async sts", sts_word, 32'h0);
    chk("R1 async outs", {irq_wdt, irq_fit, irq_dec, wdt_rearm, fit_rearm}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule